// File: doc/BRIEF.md
# Strobe-Controlled FIFO with Flow-Through

This block is a first-in first-out buffer of 9-bit words whose depth is chosen at build time as 512, 1024, 2048, 4096 or 8192 words. The writer and the reader each own an active-low strobe. Both strobes are brought into the system clock domain through a two-stage synchroniser. A word is taken in, or handed out, when its strobe goes from low to high. The block reports empty, full and half-full. A retransmit input rewinds the read side to the first location, so stored words can be read again. The output word is qualified by an output-enable that stands in for a three-state bus.

The two edge cases of a strobe-driven buffer are handled on purpose. If the reader holds its strobe low on an empty buffer and a word then arrives, that word shows up on the output without a fresh read strobe. If a writer holds its strobe low on a full buffer and a read frees a slot, the full flag stays up until the waiting word lands.

Top module: `strobe_fifo`

## Requirements
- R1: While rst_n is low, and after it is released, the buffer is empty: empty=1, full=0, half_full=0, dout_oe=0 and dout=0.
- R2: A rising edge of wr_n stores din at the tail. Its effect on the flags is visible by the third rising clock edge after the strobe change. Words are read back in the order they were written, and all 9 bits are kept.
- R3: A rising edge of wr_n while the buffer holds DEPTH words is ignored. The stored contents and their order are unchanged, and the count never goes above DEPTH.
- R4: A rising edge of rd_n removes the head word. A rising edge of rd_n on an empty buffer is ignored.
- R5: dout_oe is 1 two clock edges after rd_n goes low and 0 after rd_n returns high. While dout_oe is 1, dout shows the head word. While dout_oe is 0, dout is 0.
- R6: Read flow-through: with rd_n held low on an empty buffer, a write makes empty go to 0 and puts the new word on dout. The later rising edge of rd_n consumes the word, and empty returns to 1.
- R7: Write flow-through: if wr_n is already low when a read takes a word from a full buffer, full stays 1. The next rising edge of wr_n stores the waiting word, and full stays 1.
- R8: half_full is 1 exactly when the count is at least DEPTH/2+1. For DEPTH=512 that is 257 words.
- R9: A one-cycle pulse on retx sets the read position to location 0 and leaves the write position unchanged. The count becomes the number of words written since reset, and those words can then be read again from the first one.
- R10: Rising edges of both strobes in the same cycle on a buffer that is neither empty nor full perform both the read and the write. The count is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_n | input | 1 | write strobe, active low, stores on rising edge |
| rd_n | input | 1 | read strobe, active low, removes on rising edge |
| retx | input | 1 | retransmit pulse, synchronous to clk |
| din | input | WIDTH | word to store |
| dout | output | WIDTH | head word, 0 while not enabled |
| dout_oe | output | 1 | output enable, follows the synchronised read strobe |
| empty | output | 1 | no words stored |
| full | output | 1 | DEPTH words stored, or a waiting write is anticipated |
| half_full | output | 1 | more than half the depth occupied |

## Verification
A pointer or count that drifts from the true occupancy shows up at the ports within one strobe: the next read returns a word out of order, or a flag changes one word too early or too late. The occupancy thresholds are exercised at the exact boundary words (256/257 and DEPTH), so an off-by-one error flips a flag at a known write. A wrong rewind or an accepted write while full surfaces as a wrong word in a long drain that is compared against a model kept in the bench. A lost hold of the full flag appears as a 0 on full in the window between the read and the waiting write.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

  // occupancy after one cycle of accepted operations
  function automatic int next_count(int cnt, bit wr_ok, bit rd_ok);
    int n;
    n = cnt;
    if (wr_ok && !rd_ok) n = cnt + 1;
    if (rd_ok && !wr_ok) n = cnt - 1;
    return n;
  endfunction

  // threshold for the half-full flag
  function automatic bit above_half(int cnt, int depth);
    return cnt >= (depth / 2) + 1;
  endfunction

  // occupancy after the read side is rewound to location zero
  function automatic int rewind_count(int wr_pos);
    return wr_pos;
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic low_lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= strobe_n;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b1;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign low_lvl = ~chain[STAGES-1];
  assign rise    = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rise,
  input  logic          rd_rise,
  input  logic          wr_low,
  input  logic          retx,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] occ,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic          empty,
  output logic          full,
  output logic          half_full
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic cnt_full;
  logic cnt_zero;
  logic ft_hold;
  logic ft_set;

  assign cnt_full = (occ == CNT_MAX);
  assign cnt_zero = (occ == '0);
  assign wr_acc   = wr_rise & ~retx & ~cnt_full;
  assign rd_acc   = rd_rise & ~retx & ~cnt_zero;
  // a read frees a slot while a writer is already waiting
  assign ft_set   = rd_acc & cnt_full & wr_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (retx) begin
      rd_ptr <= '0;
      occ    <= CW'(rewind_count(int'(wr_ptr)));
    end else begin
      if (wr_acc) wr_ptr <= wr_ptr + 1'b1;
      if (rd_acc) rd_ptr <= rd_ptr + 1'b1;
      occ <= CW'(next_count(int'(occ), wr_acc, rd_acc));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  ft_hold <= 1'b0;
    else if (ft_set)                             ft_hold <= 1'b1;
    else if (retx || wr_rise || !wr_low || rd_acc) ft_hold <= 1'b0;
  end

  assign empty     = cnt_zero;
  assign full      = cnt_full | ft_hold;
  assign half_full = above_half(int'(occ), DEPTH);
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 512,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             retx,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe,
  output logic             empty,
  output logic             full,
  output logic             half_full
);
  // named internal events, brought out for the checker
  logic          wr_low, wr_rise;
  logic          rd_low, rd_rise;
  logic          wr_acc, rd_acc;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;
  logic [WIDTH-1:0] head;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .low_lvl(wr_low), .rise(wr_rise)
  );

  strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .low_lvl(rd_low), .rise(rd_rise)
  );

  fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_rise(wr_rise), .rd_rise(rd_rise), .wr_low(wr_low), .retx(retx),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ),
    .wr_acc(wr_acc), .rd_acc(rd_acc),
    .empty(empty), .full(full), .half_full(half_full)
  );

  fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_acc), .waddr(wr_ptr), .wdata(din),
    .raddr(rd_ptr), .rdata(head)
  );

  assign dout_oe = rd_low;
  assign dout    = rd_low ? head : '0;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          retx,
  input logic          wr_rise,
  input logic          rd_rise,
  input logic          wr_acc,
  input logic          rd_acc,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic [CW-1:0] occ,
  input logic          empty,
  input logic          full,
  input logic          half_full
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_MAX);

  assert_full_write_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_MAX && wr_rise) |=> $stable(wr_ptr));

  assert_empty_read_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0 && rd_rise && !retx) |=> $stable(rd_ptr));

  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !rd_acc) |=> (occ == $past(occ) + 1'b1));

  assert_pair_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && rd_acc) |=> $stable(occ));

  assert_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retx |=> (rd_ptr == '0 && $stable(wr_ptr)));

  assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  assert_half_not_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    half_full |-> !empty);
endmodule

bind strobe_fifo strobe_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .retx(retx),
  .wr_rise(wr_rise), .rd_rise(rd_rise), .wr_acc(wr_acc), .rd_acc(rd_acc),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ),
  .empty(empty), .full(full), .half_full(half_full)
);

// File: tb/tb_strobe_fifo.sv
module tb_strobe_fifo;
  localparam int W = 9;
  localparam int D = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1, rd_n = 1'b1, retx = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic dout_oe, empty, full, half_full;

  int total = 0;
  int bad = 0;
  logic [W-1:0] seen;

  always #10 clk = ~clk;

  strobe_fifo #(.WIDTH(W), .DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .retx(retx),
    .din(din), .dout(dout), .dout_oe(dout_oe),
    .empty(empty), .full(full), .half_full(half_full)
  );

  typedef struct packed {
    logic         is_rd;
    logic [W-1:0] data;
    logic         exp_empty;
    logic         exp_half;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 9'h0A1, 1'b0, 1'b0},
    '{1'b0, 9'h1F3, 1'b0, 1'b0},
    '{1'b0, 9'h055, 1'b0, 1'b0},
    '{1'b1, 9'h0A1, 1'b0, 1'b0},
    '{1'b1, 9'h1F3, 1'b0, 1'b0},
    '{1'b0, 9'h100, 1'b0, 1'b0},
    '{1'b1, 9'h055, 1'b0, 1'b0},
    '{1'b1, 9'h100, 1'b1, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [W-1:0] v);
    din = v;
    wr_n = 1'b0;
    tick(3);
    wr_n = 1'b1;
    tick(4);
  endtask

  task automatic do_read(output logic [W-1:0] v);
    rd_n = 1'b0;
    tick(3);
    v = dout;
    rd_n = 1'b1;
    tick(4);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(2);
  endtask

  initial begin
    #3000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(1);
    // R1 during and after reset
    check("R1 empty in reset", int'(empty), 1);
    rst_n = 1'b1;
    tick(2);
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 half", int'(half_full), 0);
    check("R1 oe", int'(dout_oe), 0);
    check("R1 dout", int'(dout), 0);

    // R2/R4 table of vectors
    foreach (VEC[i]) begin
      if (VEC[i].is_rd) begin
        do_read(seen);
        check("R4 read word", int'(seen), int'(VEC[i].data));
      end else begin
        do_write(VEC[i].data);
      end
      check("R2 empty flag", int'(empty), int'(VEC[i].exp_empty));
      check("R8 half flag", int'(half_full), int'(VEC[i].exp_half));
    end

    // R4 read on empty is ignored
    do_read(seen);
    check("R4 empty stays", int'(empty), 1);
    do_write(9'h077);
    do_read(seen);
    check("R4 ignored read left order", int'(seen), 'h077);

    // R5 output enable timing and quiet bus
    do_write(9'h133);
    rd_n = 1'b0;
    tick(1);
    check("R5 oe not yet", int'(dout_oe), 0);
    tick(1);
    check("R5 oe on", int'(dout_oe), 1);
    check("R5 head on bus", int'(dout), 'h133);
    rd_n = 1'b1;
    tick(4);
    check("R5 oe off", int'(dout_oe), 0);
    check("R5 bus quiet", int'(dout), 0);

    // R6 read flow-through
    rd_n = 1'b0;
    tick(4);
    check("R6 empty before", int'(empty), 1);
    do_write(9'h1C6);
    check("R6 empty drops", int'(empty), 0);
    check("R6 word on bus", int'(dout), 'h1C6);
    rd_n = 1'b1;
    tick(4);
    check("R6 empty back", int'(empty), 1);
    check("R6 oe off", int'(dout_oe), 0);

    // R10 simultaneous read and write
    do_write(9'h011);
    do_write(9'h022);
    din = 9'h033;
    wr_n = 1'b0;
    rd_n = 1'b0;
    tick(3);
    check("R10 head", int'(dout), 'h011);
    wr_n = 1'b1;
    rd_n = 1'b1;
    tick(4);
    do_read(seen);
    check("R10 second", int'(seen), 'h022);
    do_read(seen);
    check("R10 new word", int'(seen), 'h033);
    check("R10 empty after", int'(empty), 1);

    // R9 retransmit
    do_reset();
    for (int i = 0; i < 5; i++) do_write(W'(9'h040 + i));
    for (int i = 0; i < 3; i++) do_read(seen);
    retx = 1'b1;
    tick(1);
    retx = 1'b0;
    tick(1);
    check("R9 not empty", int'(empty), 0);
    for (int i = 0; i < 5; i++) begin
      do_read(seen);
      check("R9 replay", int'(seen), 'h040 + i);
    end
    check("R9 empty after replay", int'(empty), 1);

    // R8 threshold, R3 full ignore, R7 write flow-through
    do_reset();
    for (int i = 0; i < D; i++) begin
      do_write(W'(i));
      if (i == D/2 - 1) check("R8 at half", int'(half_full), 0);
      if (i == D/2)     check("R8 above half", int'(half_full), 1);
      if (i == D - 2)   check("R3 not yet full", int'(full), 0);
    end
    check("R3 full", int'(full), 1);
    do_write(9'h1AA);
    check("R3 still full", int'(full), 1);

    din = 9'h155;
    wr_n = 1'b0;
    tick(3);
    rd_n = 1'b0;
    tick(3);
    check("R3 head kept", int'(dout), 0);
    rd_n = 1'b1;
    tick(4);
    check("R7 full held", int'(full), 1);
    wr_n = 1'b1;
    tick(4);
    check("R7 full after store", int'(full), 1);

    begin
      int errs;
      errs = 0;
      for (int i = 1; i < D; i++) begin
        do_read(seen);
        if (seen != W'(i)) errs++;
      end
      check("R3 drain order", errs, 0);
      do_read(seen);
      check("R7 waiting word", int'(seen), 'h155);
      check("R4 drained", int'(empty), 1);
    end

    // R1 reset clears a partly filled buffer
    do_write(9'h0F0);
    rst_n = 1'b0;
    tick(1);
    check("R1 reset clears", int'(empty), 1);
    rst_n = 1'b1;
    tick(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule